// File: doc/BRIEF.md
# Parallel ADC Result Read Port

This block is the digital parallel-bus side of a six-channel, 16-bit sampling converter. A host raises a conversion-start strobe. The block then holds a busy flag for a fixed number of clock cycles, which stands in for the analog conversion. At the end of that time it captures one result per channel from an input vector into holding registers. The analog part is not modelled: in simulation the bench supplies the results.

The host reads the captured results through chip-select and read-strobe handshakes. Each completed read moves an internal channel pointer forward, so successive reads walk the channels in ascending order and then wrap back to channel 0.

In word mode every read returns a full 16-bit result. In byte mode each result is split into two reads on the upper eight data lines. An order input picks whether the upper byte or the lower byte comes first. The host can also write an 8-bit configuration value through the upper data lines, using chip select together with the write strobe.

The tri-state data bus is split at this boundary into an input vector, an output vector and an output enable. The pad ring joins them into one bidirectional bus. All strobes are active low and are sampled on the rising clock edge.

Top module: `adc_par_port`

## Requirements
- R1: `db_oe` is 1 exactly while `cs_n` and `rd_n` are both 0. At all other times the bus is released (`db_oe` = 0).
- R2: On each clock edge where `cs_n` and `wr_n` are both 0, `ctrl_q` takes `db_i[15:8]`. A write strobe with `cs_n` = 1 leaves `ctrl_q` unchanged.
- R3: A 0-to-1 change of `conv_start` seen while idle makes `busy` go to 1 after that clock edge. `busy` then stays 1 for exactly `CONV_CYCLES` clock cycles.
- R4: A 0-to-1 change of `conv_start` seen while `busy` is 1 is ignored. `busy` still falls `CONV_CYCLES` cycles after the original start.
- R5: On the edge where `busy` falls, channel c captures `sample_in[16*c+15 : 16*c]`. The read pointer returns to channel 0 and to the first byte of that channel.
- R6: In word mode (`byte_mode` = 0), an enabled bus carries the full 16-bit result of the pointed channel. A read completes on the clock edge where `rd_n` is sampled 1, was 0 on the previous edge, and `cs_n` is 0. Each completed read advances the pointer by one channel.
- R7: In byte mode (`byte_mode` = 1), the bus carries one byte of the pointed result on `db_o[15:8]`, and `db_o[7:0]` is 0. With `hi_first` = 1 the first read of a channel gives bits 15:8 and the second gives bits 7:0. With `hi_first` = 0 the order is reversed. The pointer moves to the next channel after every second completed read.
- R8: A completed read of channel `NUM_CH-1` moves the pointer back to channel 0.
- R9: After reset, `busy` = 0, `db_oe` = 0, `ctrl_q` = 0, every held result is 0 and the pointer is at channel 0, first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Conversion start; the rising change is used |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| byte_mode | input | 1 | 1 = byte transfers on the upper lines, 0 = word transfers |
| hi_first | input | 1 | Byte mode: 1 = upper byte on the first read, 0 = lower byte first |
| sample_in | input | NUM_CH*16 | Modelled conversion results, channel c at bits 16c+15:16c |
| db_i | input | 16 | Bus value from the pad; bits 15:8 carry control writes |
| db_o | output | 16 | Bus value to the pad |
| db_oe | output | 1 | Pad output enable |
| busy | output | 1 | Conversion in progress |
| ctrl_q | output | 8 | Control register contents |

## Verification
Word reads run over all six channels and then one more read. This separates a correct channel walk from a stuck or skipping pointer, and shows the wrap to channel 0.

Byte reads run once with each setting of `hi_first`. This separates the two byte orders, and shows that the pointer advances only after the second byte of a channel.

A conversion-start pulse is injected in the middle of a conversion. The busy length is compared with the one expected when the pulse is ignored, not with the shorter or longer length a restart would give.

A conversion is started after the pointer has been moved away from channel 0 by partial reads. The next read must return the fresh channel 0 value, which shows both the capture and the pointer reset.

// File: rtl/adc_pp_pkg.sv
package adc_pp_pkg;

    localparam int unsigned CH_COUNT     = 6;
    localparam int unsigned RES_BITS     = 16;
    localparam int unsigned CTRL_BITS    = 8;
    localparam int unsigned HALF_BITS    = RES_BITS / 2;
    localparam int unsigned CONV_LEN_DEF = 100;

    typedef enum logic {
        CV_IDLE = 1'b0,
        CV_RUN  = 1'b1
    } cv_state_e;

    typedef struct packed {
        logic busy;
        logic done;
    } cv_status_t;

    function automatic logic [HALF_BITS-1:0] byte_of(
        input logic [RES_BITS-1:0] w,
        input logic                upper
    );
        return upper ? w[RES_BITS-1:HALF_BITS] : w[HALF_BITS-1:0];
    endfunction

endpackage

// File: rtl/adc_pp_conv_timer.sv
module adc_pp_conv_timer
    import adc_pp_pkg::*;
#(
    parameter int unsigned CONV_CYCLES = CONV_LEN_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_lvl,
    output cv_status_t stat
);
    localparam int unsigned CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

    cv_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic             start_prev;
    logic             start_edge;

    assign start_edge = start_lvl & ~start_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= CV_IDLE;
            cnt        <= '0;
            start_prev <= 1'b0;
        end else begin
            start_prev <= start_lvl;
            case (st)
                CV_IDLE: begin
                    // R3: start on a rising change; while running no edge is looked at (R4)
                    if (start_edge) begin
                        st  <= CV_RUN;
                        cnt <= CNT_W'(CONV_CYCLES - 1);
                    end
                end
                CV_RUN: begin
                    if (cnt == '0) st <= CV_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= CV_IDLE;
            endcase
        end
    end

    assign stat.busy = (st == CV_RUN);
    assign stat.done = (st == CV_RUN) && (cnt == '0);

endmodule

// File: rtl/adc_pp_result_bank.sv
module adc_pp_result_bank
    import adc_pp_pkg::*;
#(
    parameter  int unsigned NUM_CH = CH_COUNT,
    localparam int unsigned PTR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [NUM_CH*RES_BITS-1:0] sample_in,
    input  logic [PTR_W-1:0]           sel,
    output logic [RES_BITS-1:0]        word_out
);
    logic [RES_BITS-1:0] held [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)       held[g] <= '0;
            else if (load) held[g] <= sample_in[g*RES_BITS +: RES_BITS];  // R5
        end
    end

    always_comb begin
        word_out = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel == PTR_W'(i)) word_out = held[i];
        end
    end

endmodule

// File: rtl/adc_pp_read_seq.sv
module adc_pp_read_seq
    import adc_pp_pkg::*;
#(
    parameter  int unsigned NUM_CH = CH_COUNT,
    localparam int unsigned PTR_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             byte_mode,
    input  logic             restart,
    output logic [PTR_W-1:0] ch_sel,
    output logic             half
);
    logic rd_prev;
    logic rd_done;
    logic at_last;

    assign rd_done = rd_n & ~rd_prev & ~cs_n;
    assign at_last = (ch_sel == PTR_W'(NUM_CH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_sel  <= '0;
            half    <= 1'b0;
            rd_prev <= 1'b1;
        end else begin
            rd_prev <= rd_n;
            if (restart) begin
                ch_sel <= '0;
                half   <= 1'b0;
            end else if (rd_done) begin
                if (byte_mode && !half) begin
                    half <= 1'b1;                            // R7: second byte next
                end else begin
                    half   <= 1'b0;
                    ch_sel <= at_last ? '0 : ch_sel + 1'b1;  // R6, R8
                end
            end
        end
    end

endmodule

// File: rtl/adc_pp_ctrl_port.sv
module adc_pp_ctrl_port
    import adc_pp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 wr_n,
    input  logic [CTRL_BITS-1:0] data_hi,
    output logic [CTRL_BITS-1:0] ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst)                 ctrl_q <= '0;
        else if (!cs_n && !wr_n) ctrl_q <= data_hi;  // R2
    end

endmodule

// File: rtl/adc_par_port.sv
module adc_par_port
    import adc_pp_pkg::*;
#(
    parameter  int unsigned NUM_CH      = CH_COUNT,
    parameter  int unsigned CONV_CYCLES = CONV_LEN_DEF,
    localparam int unsigned PTR_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       conv_start,
    input  logic                       cs_n,
    input  logic                       rd_n,
    input  logic                       wr_n,
    input  logic                       byte_mode,
    input  logic                       hi_first,
    input  logic [NUM_CH*RES_BITS-1:0] sample_in,
    input  logic [RES_BITS-1:0]        db_i,
    output logic [RES_BITS-1:0]        db_o,
    output logic                       db_oe,
    output logic                       busy,
    output logic [CTRL_BITS-1:0]       ctrl_q
);
    cv_status_t          cv;
    logic [PTR_W-1:0]    rd_ptr;
    logic                rd_half;
    logic [RES_BITS-1:0] cur_word;

    adc_pp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start_lvl (conv_start),
        .stat      (cv)
    );

    adc_pp_result_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .load      (cv.done),
        .sample_in (sample_in),
        .sel       (rd_ptr),
        .word_out  (cur_word)
    );

    adc_pp_read_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .byte_mode (byte_mode),
        .restart   (cv.done),
        .ch_sel    (rd_ptr),
        .half      (rd_half)
    );

    adc_pp_ctrl_port u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .data_hi (db_i[RES_BITS-1 -: CTRL_BITS]),
        .ctrl_q  (ctrl_q)
    );

    assign busy  = cv.busy;
    assign db_oe = ~cs_n & ~rd_n;  // R1

    always_comb begin
        if (byte_mode) begin
            // R7: first byte is the upper one when hi_first is set
            db_o = {byte_of(cur_word, hi_first ^ rd_half), {HALF_BITS{1'b0}}};
        end else begin
            db_o = cur_word;  // R6
        end
    end

endmodule

// File: rtl/adc_pp_chk.sv
module adc_pp_chk
    import adc_pp_pkg::*;
#(
    parameter  int unsigned NUM_CH      = CH_COUNT,
    parameter  int unsigned CONV_CYCLES = CONV_LEN_DEF,
    localparam int unsigned PTR_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 conv_start,
    input logic                 cs_n,
    input logic                 rd_n,
    input logic                 wr_n,
    input logic                 byte_mode,
    input logic [RES_BITS-1:0]  db_o,
    input logic                 db_oe,
    input logic                 busy,
    input logic [CTRL_BITS-1:0] ctrl_q,
    input logic [PTR_W-1:0]     rd_ptr
);
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    a_r1_bus_released: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> !db_oe);

    a_r2_ctrl_holds: assert property (@(posedge clk) disable iff (rst)
        (cs_n || wr_n) |=> $stable(ctrl_q));

    a_r3_busy_rises: assert property (@(posedge clk) disable iff (rst)
        ($rose(conv_start) && !busy) |=> busy);

    // R3 and R4: a start edge during a conversion must not stretch or cut it
    a_r4_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == CONV_CYCLES));

    a_r5_ptr_home: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (rd_ptr == '0));

    a_r7_low_lines_zero: assert property (@(posedge clk) disable iff (rst)
        (db_oe && byte_mode) |-> (db_o[HALF_BITS-1:0] == '0));

    a_r8_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        (32'(rd_ptr) < NUM_CH));

endmodule

bind adc_par_port adc_pp_chk #(
    .NUM_CH      (NUM_CH),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .byte_mode  (byte_mode),
    .db_o       (db_o),
    .db_oe      (db_oe),
    .busy       (busy),
    .ctrl_q     (ctrl_q),
    .rd_ptr     (rd_ptr)
);

// File: tb/sim_adc_par_port.sv
`timescale 1ns/1ps
module sim_adc_par_port;

    localparam int CONV = 100;
    localparam int NCH  = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conv_start = 1'b0;
    logic          cs_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          byte_mode = 1'b0;
    logic          hi_first = 1'b0;
    logic [NCH*16-1:0] sample_in = '0;
    logic [15:0]   db_i = '0;
    logic [15:0]   db_o;
    logic          db_oe;
    logic          busy;
    logic [7:0]    ctrl_q;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit ended = 0;

    always #2 clk = ~clk;  // 250 MHz

    adc_par_port #(.NUM_CH(NCH), .CONV_CYCLES(CONV)) u0 (
        .clk(clk), .rst(rst), .conv_start(conv_start), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .byte_mode(byte_mode), .hi_first(hi_first),
        .sample_in(sample_in), .db_i(db_i), .db_o(db_o), .db_oe(db_oe),
        .busy(busy), .ctrl_q(ctrl_q)
    );

    // ---------------- behavioural reference model ----------------
    int          m_busy, m_cnt, m_ptr, m_half, m_rd_prev, m_cv_prev;
    logic [15:0] m_res [NCH];
    logic [7:0]  m_ctrl;

    always @(posedge clk) begin
        bit rr, se, dn;
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_ptr = 0; m_half = 0;
            m_rd_prev = 1; m_cv_prev = 0; m_ctrl = 8'h00;
            for (int c = 0; c < NCH; c++) m_res[c] = 16'h0000;
        end else begin
            rr = rd_n && (m_rd_prev == 0) && !cs_n;
            se = conv_start && (m_cv_prev == 0) && (m_busy == 0);
            dn = (m_busy != 0) && (m_cnt == 0);
            m_rd_prev = rd_n;
            m_cv_prev = conv_start;
            if (!cs_n && !wr_n) m_ctrl = db_i[15:8];
            if (dn) begin
                for (int c = 0; c < NCH; c++) m_res[c] = sample_in[c*16 +: 16];
                m_ptr = 0; m_half = 0; m_busy = 0;
            end else begin
                if (m_busy != 0) m_cnt = m_cnt - 1;
                if (rr) begin
                    if (byte_mode && m_half == 0) m_half = 1;
                    else begin
                        m_half = 0;
                        m_ptr = (m_ptr == NCH - 1) ? 0 : m_ptr + 1;
                    end
                end
            end
            if (se) begin m_busy = 1; m_cnt = CONV - 1; end
        end
    end

    function automatic logic [15:0] model_bus();
        logic [15:0] w;
        w = m_res[m_ptr];
        if (!byte_mode) return w;
        if (hi_first ^ (m_half != 0)) return {w[15:8], 8'h00};
        return {w[7:0], 8'h00};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(posedge clk) begin
        #1;
        if (!rst && !ended) begin
            chk("R3 busy vs model", 32'(busy), 32'(m_busy != 0));
            chk("R2 ctrl_q vs model", 32'(ctrl_q), 32'(m_ctrl));
            chk("R1 db_oe vs model", 32'(db_oe), 32'(!cs_n && !rd_n));
            if (db_oe) chk("R6 R7 bus vs model", 32'(db_o), 32'(model_bus()));
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [15:0] val(input int seed, input int c);
        return 16'(seed * 4099 + c * 8209 + 17 * c * c + 3);
    endfunction

    task automatic load_vec(input int seed);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) sample_in[c*16 +: 16] = val(seed, c);
    endtask

    task automatic pulse_start();
        @(negedge clk) conv_start = 1'b1;
        @(negedge clk) conv_start = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 1000) begin @(posedge clk); #1; g++; end
        @(negedge clk);
    endtask

    task automatic do_read(input logic [15:0] exp, input string tag);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        @(posedge clk); #1;
        chk({tag, " oe"}, 32'(db_oe), 32'd1);
        chk(tag, 32'(db_o), 32'(exp));
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk("R9 busy after reset", 32'(busy), 32'd0);
        chk("R9 oe after reset", 32'(db_oe), 32'd0);
        chk("R9 ctrl after reset", 32'(ctrl_q), 32'd0);
        do_read(16'h0000, "R9 result zero after reset");

        // R3 length, R4 ignored mid-conversion start edge
        load_vec(1);
        pulse_start();
        n = 1;
        for (int k = 0; k < 1000; k++) begin
            @(posedge clk); #1;
            if (k == 40) conv_start = 1'b1;
            if (k == 41) conv_start = 1'b0;
            if (!busy) break;
            n++;
        end
        chk("R3 R4 busy length with mid start", 32'(n), 32'(CONV));
        @(negedge clk);

        // R5 R6 R8: word walk and wrap
        for (int c = 0; c < NCH; c++) do_read(val(1, c), "R6 word read");
        do_read(val(1, 0), "R8 wrap to ch0");

        // R1: either strobe alone leaves the bus released
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
        @(posedge clk); #1 chk("R1 rd without cs", 32'(db_oe), 32'd0);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
        @(posedge clk); #1 chk("R1 cs without rd", 32'(db_oe), 32'd0);
        @(negedge clk); cs_n = 1'b1;

        // R2: control write and ignored write
        @(negedge clk); db_i = 16'hA55A; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
        @(posedge clk); #1 chk("R2 ctrl written", 32'(ctrl_q), 32'hA5);
        @(negedge clk); db_i = 16'h3CC3; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; db_i = 16'h0000;
        @(posedge clk); #1 chk("R2 write without cs ignored", 32'(ctrl_q), 32'hA5);

        // R5: pointer moved away, new conversion brings fresh ch0
        load_vec(2);
        pulse_start();
        wait_idle();
        do_read(val(2, 0), "R5 fresh ch0 after conversion");
        do_read(val(2, 1), "R5 fresh ch1");

        // R7 byte mode, upper byte first
        load_vec(3);
        pulse_start();
        wait_idle();
        byte_mode = 1'b1; hi_first = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            do_read({val(3, c)[15:8], 8'h00}, "R7 hi-first upper");
            do_read({val(3, c)[7:0], 8'h00}, "R7 hi-first lower");
        end

        // R7 byte mode, lower byte first, then R8 wrap
        load_vec(4);
        pulse_start();
        wait_idle();
        hi_first = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            do_read({val(4, c)[7:0], 8'h00}, "R7 lo-first lower");
            do_read({val(4, c)[15:8], 8'h00}, "R7 lo-first upper");
        end
        do_read({val(4, 0)[7:0], 8'h00}, "R8 byte wrap to ch0");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule